// File: doc/BRIEF.md
# Single-Precision Floating-Point Divider with Divide-by-Zero Trap

The block divides a single-precision floating-point dividend by a divisor over a fixed number of clock cycles. The divisor is either a single-precision value or a signed 32-bit two's-complement integer. An integer divisor is converted to single precision, with round-to-nearest-even, before the division starts. The mantissa quotient comes from a restoring divider that yields one bit per cycle. Guard, round and sticky bits feed a round-to-nearest-even step. Zeros, infinities and NaNs take a shortcut path that is chosen when the operation is accepted. Denormal inputs are flushed to zero.

A divisor of zero raises a divide-by-zero flag. A mask input then chooses the outcome. With the mask set, the unit writes an infinity whose sign is the XOR of the operand signs. With the mask clear, it leaves the destination untouched. A two-bit precision tag sets the reported latency. Done does not rise until the tagged cycle count has elapsed, even though the single-precision result is ready sooner.

The handshake is plain start/busy/done. The unit accepts start only in a cycle where busy is low, and it ignores start while busy is high. The caller applies back-pressure simply by holding start low. The result side has no back-pressure: done and wr_en are one-cycle pulses. The quotient, the flag and the rounded-up bit stay stable from done until the next accepted operation completes.

Top module: `fpdiv_unit`

## Requirements
- R1: After reset, busy, done, wr_en, zdiv_flag and rnd_up are 0 and quotient is 0x00000000.
- R2: An operation is accepted on a rising edge with start high and busy low. busy is high from that edge on, and done is a one-cycle pulse that rises exactly N edges after the accepting edge, with busy low in that cycle. N is 30 for prec=0, 40 for prec=1, and 44 for prec=2 or prec=3.
- R3: For normal operands whose quotient is in the normal range, quotient equals the IEEE single-precision quotient rounded to nearest-even, and wr_en pulses with done.
- R4: rnd_up is 1 when rounding of a finite normal result incremented its magnitude, and 0 in every other case, including special results.
- R5: With src_int=1, divisor is read as a signed 32-bit two's-complement integer and converted to single precision with round-to-nearest-even before dividing.
- R6: A zero divisor (float +0, -0, a denormal, or integer 0, which counts as +0) with a dividend that is neither NaN nor zero sets zdiv_flag=1. When zmask=1, the result {sign_a XOR sign_b, 0xFF, 0} is written. zdiv_flag is 0 for every other operation.
- R7: When the divide-by-zero case of R6 occurs with zmask=0, wr_en stays 0 at done and quotient keeps its previous value.
- R8: A NaN dividend gives the dividend with fraction bit 22 set. Otherwise a NaN divisor gives the divisor with fraction bit 22 set. This NaN handling takes precedence over every other case.
- R9: Zero divided by zero and infinity divided by infinity give 0x7FC00000 and do not set zdiv_flag.
- R10: Infinity divided by a finite value gives an infinity. A zero or denormal dividend, or an infinite divisor, gives a zero. In both cases the sign is the XOR of the operand signs.
- R11: A result exponent above the single-precision range gives a signed infinity. One below the normal range gives a signed zero.
- R12: A start pulse while busy is high has no effect: neither the running result nor the time of its done changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a divide; taken only when busy is low |
| dividend | input | 32 | Single-precision dividend |
| divisor | input | 32 | Single-precision divisor, or signed integer when src_int=1 |
| src_int | input | 1 | 1: divisor is a signed 32-bit integer |
| zmask | input | 1 | 1: divide-by-zero masked, signed infinity written |
| prec | input | 2 | Precision tag selecting the reported latency |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Result, held between completions |
| wr_en | output | 1 | Destination write strobe, pulses with done |
| zdiv_flag | output | 1 | Divide-by-zero detected in the last operation |
| rnd_up | output | 1 | Last result was rounded up in magnitude |

## Verification
A fault in the restoring iteration counter or the remainder register stays hidden until done, roughly thirty cycles later. It then shows as wrong low quotient bits or a wrong rnd_up, so vectors whose results hinge on the final guard and sticky bits are the ones that expose it. A fault in the latency counter or the captured precision tag shows as done rising early or late. That appears on the very pulse of the faulty operation, so every operation has its done edge counted. A mistaken special-case choice, made when the operation is accepted, appears as a wrong NaN payload, a wrong sign, or a wrong wr_en/zdiv_flag pair on the first done after it.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int QBITS  = SIG_W + 4;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0]  EXP_MAX = '1;
  localparam logic [WORD_W-1:0] QUIET_MASK =
    {{(1 + EXP_W){1'b0}}, 1'b1, {(FRAC_W - 1){1'b0}}};
  localparam logic [WORD_W-1:0] QNAN_DEFAULT =
    {1'b0, EXP_MAX, 1'b1, {(FRAC_W - 1){1'b0}}};

  typedef enum logic [1:0] {FC_ZERO, FC_NORM, FC_INF, FC_NAN} fclass_t;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [SIG_W-1:0] sig;
    fclass_t          cls;
  } fval_t;

  // Split a word into fields; denormals are classed as zero.
  function automatic fval_t split(input logic [WORD_W-1:0] x);
    fval_t u;
    u.sign = x[WORD_W-1];
    u.exp  = x[WORD_W-2 -: EXP_W];
    u.sig  = {1'b1, x[FRAC_W-1:0]};
    if (u.exp == '0) begin
      u.cls = FC_ZERO;
      u.sig = '0;
    end else if (u.exp == EXP_MAX) begin
      u.cls = (x[FRAC_W-1:0] == '0) ? FC_INF : FC_NAN;
    end else begin
      u.cls = FC_NORM;
    end
    return u;
  endfunction
endpackage

// File: rtl/fpdiv_i2f.sv
module fpdiv_i2f
  import fpdiv_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic [INT_W-1:0]  ival,
  output logic [WORD_W-1:0] fval
);
  localparam int LZ_W = $clog2(INT_W);
  localparam int DROP = INT_W - SIG_W;

  logic              neg, found, guard, sticky, inc;
  logic [INT_W-1:0]  mag, norm;
  logic [LZ_W-1:0]   lz;
  logic [SIG_W-1:0]  keep;
  logic [SIG_W:0]    sum;
  logic [EXP_W-1:0]  e;

  always_comb begin
    neg   = ival[INT_W-1];
    mag   = neg ? (~ival + 1'b1) : ival;
    lz    = '0;
    found = 1'b0;
    for (int i = INT_W - 1; i >= 0; i--) begin
      if (!found && mag[i]) begin
        lz    = LZ_W'(INT_W - 1 - i);
        found = 1'b1;
      end
    end
    norm   = mag << lz;
    keep   = norm[INT_W-1 -: SIG_W];
    guard  = norm[DROP-1];
    sticky = |norm[DROP-2:0];
    inc    = guard & (sticky | keep[0]);
    sum    = {1'b0, keep} + {{SIG_W{1'b0}}, inc};
    e      = EXP_W'(BIAS + INT_W - 1) - EXP_W'(lz) + EXP_W'(sum[SIG_W]);
    if (!found) fval = '0;
    else        fval = {neg, e, sum[FRAC_W-1:0]};
  end
endmodule

// File: rtl/fpdiv_iter.sv
module fpdiv_iter #(
  parameter int SIG_W = 24,
  parameter int QB    = SIG_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SIG_W-1:0] num,
  input  logic [SIG_W-1:0] den,
  output logic [QB-1:0]    quo,
  output logic             rem_nz
);
  localparam int R_W = SIG_W + 2;
  localparam int C_W = $clog2(QB + 1);

  logic [R_W-1:0] rem, den_x, diff;
  logic [C_W-1:0] left;
  logic           take;

  assign den_x  = {2'b00, den};
  assign take   = (rem >= den_x);
  assign diff   = take ? (rem - den_x) : rem;
  assign rem_nz = |rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      quo  <= '0;
      left <= '0;
    end else if (load) begin
      rem  <= {2'b00, num};
      quo  <= '0;
      left <= C_W'(QB);
    end else if (left != '0) begin
      rem  <= diff << 1;
      quo  <= {quo[QB-2:0], take};
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/fpdiv_pack.sv
module fpdiv_pack
  import fpdiv_pkg::*;
(
  input  logic                    sign,
  input  logic signed [EXP_W+1:0] ediff,
  input  logic [QBITS-1:0]        quo,
  input  logic                    rem_nz,
  output logic [WORD_W-1:0]       res,
  output logic                    rounded
);
  logic                    g, r, s, inc;
  logic [SIG_W-1:0]        m;
  logic [SIG_W:0]          sum;
  logic signed [EXP_W+1:0] e0, e1;

  always_comb begin
    if (quo[QBITS-1]) begin
      m  = quo[QBITS-1 -: SIG_W];
      g  = quo[3];
      r  = quo[2];
      s  = (|quo[1:0]) | rem_nz;
      e0 = ediff;
    end else begin
      m  = quo[QBITS-2 -: SIG_W];
      g  = quo[2];
      r  = quo[1];
      s  = quo[0] | rem_nz;
      e0 = ediff - 1;
    end
    inc = g & (r | s | m[0]);
    sum = {1'b0, m} + {{SIG_W{1'b0}}, inc};
    e1  = e0 + $signed({{(EXP_W + 1){1'b0}}, sum[SIG_W]});
    if (e1 >= $signed({2'b00, EXP_MAX})) begin
      res     = {sign, EXP_MAX, {FRAC_W{1'b0}}};
      rounded = 1'b0;
    end else if (e1 <= 0) begin
      res     = {sign, {(WORD_W - 1){1'b0}}};
      rounded = 1'b0;
    end else begin
      res     = {sign, e1[EXP_W-1:0], sum[FRAC_W-1:0]};
      rounded = inc;
    end
  end
endmodule

// File: rtl/fpdiv_unit.sv
module fpdiv_unit
  import fpdiv_pkg::*;
#(
  parameter int LAT_SP = 30,
  parameter int LAT_DP = 40,
  parameter int LAT_EP = 44
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] dividend,
  input  logic [31:0] divisor,
  input  logic        src_int,
  input  logic        zmask,
  input  logic [1:0]  prec,
  output logic        busy,
  output logic        done,
  output logic [31:0] quotient,
  output logic        wr_en,
  output logic        zdiv_flag,
  output logic        rnd_up
);
  localparam int LAT_HI  = (LAT_DP > LAT_SP) ? LAT_DP : LAT_SP;
  localparam int LAT_MAX = (LAT_EP > LAT_HI) ? LAT_EP : LAT_HI;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  logic                    accept, sgn;
  logic [WORD_W-1:0]       conv_b, b_word, spec_word, pack_res;
  fval_t                   ua, ub;
  logic                    spec_hit, spec_z, spec_drop;
  logic signed [EXP_W+1:0] ediff;
  logic [CNT_W-1:0]        lat_pick, lat_q, cnt;
  logic [QBITS-1:0]        quo;
  logic                    rem_nz, pack_rnd;

  logic                    hit_q, z_q, drop_q, sgn_q;
  logic [WORD_W-1:0]       word_q;
  logic signed [EXP_W+1:0] ediff_q;

  assign accept = start & ~busy;

  fpdiv_i2f #(.INT_W(WORD_W)) u_i2f (
    .ival (divisor),
    .fval (conv_b)
  );

  assign b_word = src_int ? conv_b : divisor;
  assign ua     = split(dividend);
  assign ub     = split(b_word);
  assign sgn    = ua.sign ^ ub.sign;
  assign ediff  = $signed({2'b00, ua.exp}) - $signed({2'b00, ub.exp})
                + (EXP_W + 2)'(BIAS);

  always_comb begin
    unique case (prec)
      2'd0:    lat_pick = CNT_W'(LAT_SP);
      2'd1:    lat_pick = CNT_W'(LAT_DP);
      default: lat_pick = CNT_W'(LAT_EP);
    endcase
  end

  // Special operands are resolved at accept time; priority is NaN first.
  always_comb begin
    spec_hit  = 1'b1;
    spec_z    = 1'b0;
    spec_drop = 1'b0;
    spec_word = '0;
    if (ua.cls == FC_NAN) begin
      spec_word = dividend | QUIET_MASK;
    end else if (ub.cls == FC_NAN) begin
      spec_word = b_word | QUIET_MASK;
    end else if ((ua.cls == FC_ZERO && ub.cls == FC_ZERO) ||
                 (ua.cls == FC_INF  && ub.cls == FC_INF)) begin
      spec_word = QNAN_DEFAULT;
    end else if (ub.cls == FC_ZERO) begin
      spec_z    = 1'b1;
      spec_drop = ~zmask;
      spec_word = {sgn, EXP_MAX, {FRAC_W{1'b0}}};
    end else if (ua.cls == FC_INF) begin
      spec_word = {sgn, EXP_MAX, {FRAC_W{1'b0}}};
    end else if (ua.cls == FC_ZERO || ub.cls == FC_INF) begin
      spec_word = {sgn, {(WORD_W - 1){1'b0}}};
    end else begin
      spec_hit  = 1'b0;
    end
  end

  fpdiv_iter #(.SIG_W(SIG_W), .QB(QBITS)) u_iter (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .num    (ua.sig),
    .den    (ub.sig),
    .quo    (quo),
    .rem_nz (rem_nz)
  );

  fpdiv_pack u_pack (
    .sign    (sgn_q),
    .ediff   (ediff_q),
    .quo     (quo),
    .rem_nz  (rem_nz),
    .res     (pack_res),
    .rounded (pack_rnd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      wr_en     <= 1'b0;
      quotient  <= '0;
      zdiv_flag <= 1'b0;
      rnd_up    <= 1'b0;
      cnt       <= '0;
      lat_q     <= '0;
      hit_q     <= 1'b0;
      z_q       <= 1'b0;
      drop_q    <= 1'b0;
      sgn_q     <= 1'b0;
      word_q    <= '0;
      ediff_q   <= '0;
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        cnt     <= CNT_W'(1);
        lat_q   <= lat_pick;
        hit_q   <= spec_hit;
        z_q     <= spec_z;
        drop_q  <= spec_drop;
        sgn_q   <= sgn;
        word_q  <= spec_word;
        ediff_q <= ediff;
      end else if (busy) begin
        if (cnt == lat_q) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          zdiv_flag <= z_q;
          if (hit_q) begin
            rnd_up <= 1'b0;
            if (!drop_q) begin
              quotient <= word_q;
              wr_en    <= 1'b1;
            end
          end else begin
            quotient <= pack_res;
            rnd_up   <= pack_rnd;
            wr_en    <= 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fpdiv_unit_chk.sv
module fpdiv_unit_chk #(
  parameter int LAT_SP = 30,
  parameter int LAT_DP = 40,
  parameter int LAT_EP = 44
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [1:0]  prec,
  input logic        a_sign,
  input logic        b_sign,
  input logic        busy,
  input logic        done,
  input logic        wr_en,
  input logic        zdiv_flag,
  input logic        rnd_up,
  input logic [31:0] quotient
);
  logic [7:0] ccnt, exp_lat;
  logic       sx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccnt    <= '0;
      exp_lat <= '0;
      sx      <= 1'b0;
    end else if (start && !busy) begin
      ccnt    <= 8'd1;
      sx      <= a_sign ^ b_sign;
      exp_lat <= (prec == 2'd0) ? 8'(LAT_SP) :
                 (prec == 2'd1) ? 8'(LAT_DP) : 8'(LAT_EP);
    end else if (busy) begin
      ccnt <= ccnt + 8'd1;
    end
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // Also covers R12: a restart while busy would move the done edge.
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ccnt == exp_lat + 8'd1));
  assert_busy_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
  assert_wr_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> done);
  assert_zero_inf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zdiv_flag && wr_en) |-> (quotient == {sx, 8'hFF, 23'h0}));
  assert_round_finite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rnd_up) |-> (wr_en && quotient[30:23] != 8'hFF));
endmodule

bind fpdiv_unit fpdiv_unit_chk #(
  .LAT_SP(LAT_SP), .LAT_DP(LAT_DP), .LAT_EP(LAT_EP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .prec      (prec),
  .a_sign    (dividend[31]),
  .b_sign    (divisor[31]),
  .busy      (busy),
  .done      (done),
  .wr_en     (wr_en),
  .zdiv_flag (zdiv_flag),
  .rnd_up    (rnd_up),
  .quotient  (quotient)
);

// File: tb/fpdiv_unit_tb.sv
`timescale 1ns/1ps
module fpdiv_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dividend = '0, divisor = '0;
  logic        src_int = 1'b0, zmask = 1'b0;
  logic [1:0]  prec = 2'd0;
  logic        busy, done, wr_en, zdiv_flag, rnd_up;
  logic [31:0] quotient;
  int          checks = 0, errors = 0;
  bit          finished = 0;

  always #10 clk = ~clk;

  fpdiv_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .src_int(src_int), .zmask(zmask), .prec(prec),
    .busy(busy), .done(done), .quotient(quotient), .wr_en(wr_en),
    .zdiv_flag(zdiv_flag), .rnd_up(rnd_up)
  );

  // {a, b, src_int, zmask, quotient, zdiv_flag, wr_en, rnd_up}
  localparam int NV = 24;
  localparam logic [100:0] VECS [NV] = '{
    {32'h3F800000, 32'h40000000, 1'b0, 1'b0, 32'h3F000000, 1'b0, 1'b1, 1'b0},
    {32'h40C00000, 32'h40400000, 1'b0, 1'b0, 32'h40000000, 1'b0, 1'b1, 1'b0},
    {32'h3F800000, 32'h40400000, 1'b0, 1'b0, 32'h3EAAAAAB, 1'b0, 1'b1, 1'b1},
    {32'h40A00000, 32'h40400000, 1'b0, 1'b0, 32'h3FD55555, 1'b0, 1'b1, 1'b0},
    {32'h3F800000, 32'h41200000, 1'b0, 1'b0, 32'h3DCCCCCD, 1'b0, 1'b1, 1'b1},
    {32'hC1200000, 32'h40000000, 1'b0, 1'b0, 32'hC0A00000, 1'b0, 1'b1, 1'b0},
    {32'h41200000, 32'hFFFFFFFC, 1'b1, 1'b0, 32'hC0200000, 1'b0, 1'b1, 1'b0},
    {32'h4B800000, 32'h01000001, 1'b1, 1'b0, 32'h3F800000, 1'b0, 1'b1, 1'b0},
    {32'h4B800002, 32'h01000003, 1'b1, 1'b0, 32'h3F800000, 1'b0, 1'b1, 1'b0},
    {32'hCF000000, 32'h80000000, 1'b1, 1'b0, 32'h3F800000, 1'b0, 1'b1, 1'b0},
    {32'h40400000, 32'h80000000, 1'b0, 1'b1, 32'hFF800000, 1'b1, 1'b1, 1'b0},
    {32'hC0000000, 32'h00000000, 1'b1, 1'b1, 32'hFF800000, 1'b1, 1'b1, 1'b0},
    {32'h7FC00001, 32'h3F800000, 1'b0, 1'b0, 32'h7FC00001, 1'b0, 1'b1, 1'b0},
    {32'h7F800001, 32'h3F800000, 1'b0, 1'b0, 32'h7FC00001, 1'b0, 1'b1, 1'b0},
    {32'h3F800000, 32'hFFA00000, 1'b0, 1'b0, 32'hFFE00000, 1'b0, 1'b1, 1'b0},
    {32'h7FC12345, 32'h00000000, 1'b0, 1'b0, 32'h7FC12345, 1'b0, 1'b1, 1'b0},
    {32'h7F800000, 32'hFF800000, 1'b0, 1'b0, 32'h7FC00000, 1'b0, 1'b1, 1'b0},
    {32'h00000000, 32'h80000000, 1'b0, 1'b0, 32'h7FC00000, 1'b0, 1'b1, 1'b0},
    {32'hFF800000, 32'h40000000, 1'b0, 1'b0, 32'hFF800000, 1'b0, 1'b1, 1'b0},
    {32'h40000000, 32'h7F800000, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b1, 1'b0},
    {32'h00000001, 32'h3F800000, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b1, 1'b0},
    {32'h80000000, 32'h3F800000, 1'b0, 1'b0, 32'h80000000, 1'b0, 1'b1, 1'b0},
    {32'h7F000000, 32'h3E800000, 1'b0, 1'b0, 32'h7F800000, 1'b0, 1'b1, 1'b0},
    {32'h80800000, 32'h40800000, 1'b0, 1'b0, 32'h80000000, 1'b0, 1'b1, 1'b0}
  };

  function automatic string req_of(int idx);
    if (idx <= 1 || idx == 5) return "R3";
    if (idx <= 4)  return "R4";
    if (idx <= 9)  return "R5";
    if (idx <= 11) return "R6";
    if (idx <= 15) return "R8";
    if (idx <= 17) return "R9";
    if (idx <= 21) return "R10";
    return "R11";
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Drive one operation; return edges from accept to done seen high.
  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        input logic si, input logic zm, input logic [1:0] pr,
                        output int lat);
    @(negedge clk);
    dividend = a; divisor = b; src_int = si; zmask = zm; prec = pr;
    start = 1'b1;
    @(posedge clk);
    lat = 0;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "busy after accept", {31'b0, busy}, 32'd1);
    while (!done && lat < 100) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int lat;
    logic [100:0] v;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", {31'b0, busy}, 32'd0);
    chk("R1", "done", {31'b0, done}, 32'd0);
    chk("R1", "wr_en", {31'b0, wr_en}, 32'd0);
    chk("R1", "zdiv_flag", {31'b0, zdiv_flag}, 32'd0);
    chk("R1", "rnd_up", {31'b0, rnd_up}, 32'd0);
    chk("R1", "quotient", quotient, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      run_op(v[100:69], v[68:37], v[36], v[35], 2'd0, lat);
      chk("R2", "latency single", lat, 32'd30);
      chk(req_of(i), "quotient", quotient, v[34:3]);
      chk(req_of(i), "zdiv_flag", {31'b0, zdiv_flag}, {31'b0, v[2]});
      chk(req_of(i), "wr_en", {31'b0, wr_en}, {31'b0, v[1]});
      chk("R4", "rnd_up", {31'b0, rnd_up}, {31'b0, v[0]});
    end

    // R2: latency per tag, one-cycle pulse, results held
    run_op(32'h40C00000, 32'h40400000, 1'b0, 1'b0, 2'd1, lat);
    chk("R2", "latency double", lat, 32'd40);
    run_op(32'h40C00000, 32'h40400000, 1'b0, 1'b0, 2'd2, lat);
    chk("R2", "latency extended", lat, 32'd44);
    run_op(32'h40C00000, 32'h40400000, 1'b0, 1'b0, 2'd3, lat);
    chk("R2", "latency tag 3", lat, 32'd44);
    chk("R2", "busy at done", {31'b0, busy}, 32'd0);
    @(negedge clk);
    chk("R2", "done pulse width", {31'b0, done}, 32'd0);
    chk("R2", "wr_en pulse width", {31'b0, wr_en}, 32'd0);
    chk("R2", "quotient held", quotient, 32'h40000000);

    // R7: unmasked divide by zero keeps previous result
    run_op(32'h3F800000, 32'h40400000, 1'b0, 1'b0, 2'd0, lat);
    held = quotient;
    run_op(32'h40400000, 32'h00000000, 1'b0, 1'b0, 2'd0, lat);
    chk("R7", "latency", lat, 32'd30);
    chk("R7", "wr_en low", {31'b0, wr_en}, 32'd0);
    chk("R6", "zdiv_flag unmasked", {31'b0, zdiv_flag}, 32'd1);
    chk("R7", "quotient unchanged", quotient, held);
    chk("R7", "done", {31'b0, done}, 32'd1);

    // R12: start while busy is ignored
    @(negedge clk);
    dividend = 32'h3F800000; divisor = 32'h40400000;
    src_int = 1'b0; zmask = 1'b0; prec = 2'd0; start = 1'b1;
    @(posedge clk);
    lat = 0;
    @(negedge clk);
    start = 1'b0;
    repeat (5) begin @(posedge clk); lat++; @(negedge clk); end
    dividend = 32'h40C00000; prec = 2'd2; start = 1'b1;
    @(posedge clk); lat++;
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 100) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    chk("R12", "latency unchanged", lat, 32'd30);
    chk("R12", "quotient of first op", quotient, 32'h3EAAAAAB);
    chk("R12", "zdiv_flag cleared", {31'b0, zdiv_flag}, 32'd0);
    @(negedge clk);
    chk("R12", "no second done", {31'b0, done | busy}, 32'd0);

    summary();
  end
endmodule